// File: doc/BRIEF.md
# Pattern Fetch A12 Sequencer

This block is the timing generator for the pattern-table side of a tile-based video fetcher. It counts dots within a picture line of 341 dots (0 to 340) and counts lines within a frame. For every dot it produces the value of address bit 12 on the pattern bus, which selects between pattern table 0 and pattern table 1. A mapper-side scanline counter watches this bit for rising edges, so where those edges fall inside the line is what matters.

Each line is split into 42 fetch slots of 8 dots. Slots 0 to 31 fetch background tiles, slots 32 to 39 fetch sprite tiles, and slots 40 and 41 prefetch two background tiles for the next line. Dots 336 to 340 are idle. Inside a slot, bit 12 is driven high at slot offsets 4 and 5 when that slot reads from table 1, and low on every other dot. The fetch schedule runs whenever rendering is enabled, whichever layer is shown. When rendering is disabled, bit 12 follows bit 12 of the address the CPU has placed on the video memory port. When sprites are 8x16, each sprite slot takes its table from its own input bit and not from the global sprite table select.

Top module: `pattern_a12_seq`

## Requirements
- R1: While reset is high, after a clock edge `dot` is 0, `line` is 0 and `a12` is 0.
- R2: `dot` advances by one per clock and goes from 340 back to 0.
- R3: `line` holds its value except on the edge where `dot` goes from 340 to 0, when it advances by one; from `LINES-1` it goes back to 0.
- R4: With rendering enabled, `a12` is high only on dots 8k+4 and 8k+5 for slot k in 0..41, and low on dots 336 to 340; each rise therefore falls on a dot whose low three bits are 4.
- R5: Slots 0 to 31 and slots 40 and 41 drive `a12` high in their high window exactly when `bg_tbl` is 1.
- R6: With `spr_tall` at 0, slots 32 to 39 drive `a12` high in their high window exactly when `spr_tbl` is 1.
- R7: With `spr_tall` at 1, slot 32+j (j in 0..7) drives `a12` high in its high window exactly when `spr_slot_tbl[j]` is 1, and `spr_tbl` has no effect.
- R8: With `render_en` at 0, `a12` after an edge equals `vram_a12` sampled at that edge, and the table selects have no effect.
- R9: With background at table 0 and sprites at table 1, a rendered line has exactly 8 rises of `a12`, the first at dot 260. With the tables the other way round, a line has 34 rises, the first one after the visible tiles is at dot 324, and the rise at dot 4 comes 13 dots after the rise at dot 332 of the line before.
- R10: All outputs are registered; a change on any input is seen on `a12` after the next clock edge, together with the `dot` value that edge produces.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Dot clock |
| rst | input | 1 | Synchronous active-high reset |
| render_en | input | 1 | 1 when either background or sprites are being rendered |
| bg_tbl | input | 1 | Pattern table used by background fetches |
| spr_tbl | input | 1 | Pattern table used by sprite fetches in 8x8 mode |
| spr_tall | input | 1 | 1 selects 8x16 sprites with per-slot tables |
| spr_slot_tbl | input | 8 | Per-slot pattern table for 8x16 sprites, bit j for sprite slot j |
| vram_a12 | input | 1 | Bit 12 of the CPU-side video memory address |
| dot | output | 9 | Current dot within the line, 0 to 340 |
| line | output | 9 | Current line within the frame |
| a12 | output | 1 | Pattern bus address bit 12 for the current dot |

## Verification
The hardest case to reach is the boundary between two lines when background fetches use table 1: the 13-dot gap from the rise at dot 332 to the rise at dot 4 exists only if the configuration holds across the wrap and the idle dots really stay low. The stimulus therefore holds each table configuration for whole lines, changing it only at dot 340, and tracks rise positions across the wrap in absolute cycles. Mid-line changes of the selects, 8x16 per-slot patterns and a pseudo-random CPU address bit with rendering off are mixed in, with a reference model compared on every clock.

// File: rtl/pattern_a12_pkg.sv
package pattern_a12_pkg;

  typedef enum logic [1:0] {
    FETCH_BG   = 2'd0,
    FETCH_SPR  = 2'd1,
    FETCH_IDLE = 2'd2
  } fetch_kind_e;

endpackage

// File: rtl/dot_line_counter.sv
module dot_line_counter #(
  parameter int DOTS_PER_LINE = 341,
  parameter int LINES         = 262,
  localparam int DW = $clog2(DOTS_PER_LINE),
  localparam int LW = $clog2(LINES)
) (
  input  logic          clk,
  input  logic          rst,
  output logic [DW-1:0] dot_q,
  output logic [LW-1:0] line_q,
  output logic [DW-1:0] dot_nxt
);

  localparam logic [DW-1:0] LAST_DOT  = DW'(DOTS_PER_LINE - 1);
  localparam logic [LW-1:0] LAST_LINE = LW'(LINES - 1);

  logic wrap;
  logic [LW-1:0] line_nxt;

  always_comb begin
    wrap     = (dot_q == LAST_DOT);
    dot_nxt  = wrap ? '0 : dot_q + 1'b1;
    line_nxt = line_q;
    if (wrap) line_nxt = (line_q == LAST_LINE) ? '0 : line_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dot_q  <= '0;
      line_q <= '0;
    end else begin
      dot_q  <= dot_nxt;
      line_q <= line_nxt;
    end
  end

endmodule

// File: rtl/fetch_slot_decode.sv
module fetch_slot_decode
  import pattern_a12_pkg::*;
#(
  parameter int DOTS_PER_LINE = 341,
  parameter int SLOT_DOTS     = 8,
  parameter int BG_FRONT      = 32,
  parameter int SPR_SLOTS     = 8,
  parameter int BG_BACK       = 2,
  parameter int HI_OFFSET     = 4,
  parameter int HI_LEN        = 2,
  localparam int DW  = $clog2(DOTS_PER_LINE),
  localparam int SIW = (SPR_SLOTS > 1) ? $clog2(SPR_SLOTS) : 1,
  localparam int PW  = $clog2(SLOT_DOTS)
) (
  input  logic [DW-1:0]  dot,
  output fetch_kind_e    kind,
  output logic [SIW-1:0] spr_idx,
  output logic           in_hi
);

  localparam int SLOTS      = BG_FRONT + SPR_SLOTS + BG_BACK;
  localparam int SPR_FIRST  = BG_FRONT;
  localparam int SPR_END    = BG_FRONT + SPR_SLOTS;

  logic [DW-1:0] slot;
  logic [PW-1:0] phase;
  logic [DW-1:0] spr_off;

  always_comb begin
    slot    = dot >> PW;
    phase   = dot[PW-1:0];
    spr_off = slot - DW'(SPR_FIRST);
    spr_idx = spr_off[SIW-1:0];
    in_hi   = (int'(phase) >= HI_OFFSET) && (int'(phase) < HI_OFFSET + HI_LEN);
    if (int'(slot) >= SLOTS)
      kind = FETCH_IDLE;
    else if (int'(slot) >= SPR_FIRST && int'(slot) < SPR_END)
      kind = FETCH_SPR;
    else
      kind = FETCH_BG;
  end

endmodule

// File: rtl/pattern_a12_seq.sv
module pattern_a12_seq
  import pattern_a12_pkg::*;
#(
  parameter int DOTS_PER_LINE = 341,
  parameter int LINES         = 262,
  parameter int SLOT_DOTS     = 8,
  parameter int BG_FRONT      = 32,
  parameter int SPR_SLOTS     = 8,
  parameter int BG_BACK       = 2,
  parameter int HI_OFFSET     = 4,
  parameter int HI_LEN        = 2,
  localparam int DW  = $clog2(DOTS_PER_LINE),
  localparam int LW  = $clog2(LINES),
  localparam int SIW = (SPR_SLOTS > 1) ? $clog2(SPR_SLOTS) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 render_en,
  input  logic                 bg_tbl,
  input  logic                 spr_tbl,
  input  logic                 spr_tall,
  input  logic [SPR_SLOTS-1:0] spr_slot_tbl,
  input  logic                 vram_a12,
  output logic [DW-1:0]        dot,
  output logic [LW-1:0]        line,
  output logic                 a12
);

  logic [DW-1:0]        dot_nxt;
  fetch_kind_e          kind;
  logic [SIW-1:0]       spr_idx;
  logic                 in_hi;
  logic [SPR_SLOTS-1:0] spr_sel;
  logic                 tbl_now;
  logic                 a12_nxt;

  dot_line_counter #(
    .DOTS_PER_LINE(DOTS_PER_LINE),
    .LINES        (LINES)
  ) u_cnt (
    .clk    (clk),
    .rst    (rst),
    .dot_q  (dot),
    .line_q (line),
    .dot_nxt(dot_nxt)
  );

  // Decode the dot that the next edge will show, so a12 lines up with dot.
  fetch_slot_decode #(
    .DOTS_PER_LINE(DOTS_PER_LINE),
    .SLOT_DOTS    (SLOT_DOTS),
    .BG_FRONT     (BG_FRONT),
    .SPR_SLOTS    (SPR_SLOTS),
    .BG_BACK      (BG_BACK),
    .HI_OFFSET    (HI_OFFSET),
    .HI_LEN       (HI_LEN)
  ) u_dec (
    .dot    (dot_nxt),
    .kind   (kind),
    .spr_idx(spr_idx),
    .in_hi  (in_hi)
  );

  for (genvar j = 0; j < SPR_SLOTS; j++) begin : g_spr_sel
    assign spr_sel[j] = spr_tall ? spr_slot_tbl[j] : spr_tbl;
  end

  always_comb begin
    unique case (kind)
      FETCH_BG:  tbl_now = bg_tbl;
      FETCH_SPR: tbl_now = spr_sel[spr_idx];
      default:   tbl_now = 1'b0;
    endcase
    a12_nxt = render_en ? (in_hi & tbl_now) : vram_a12;
  end

  always_ff @(posedge clk) begin
    if (rst) a12 <= 1'b0;
    else     a12 <= a12_nxt;
  end

endmodule

// File: rtl/pattern_a12_seq_chk.sv
module pattern_a12_seq_chk #(
  parameter int DOTS_PER_LINE = 341,
  parameter int LINES         = 262,
  localparam int DW = $clog2(DOTS_PER_LINE),
  localparam int LW = $clog2(LINES)
) (
  input logic          clk,
  input logic          rst,
  input logic          render_en,
  input logic          vram_a12,
  input logic [DW-1:0] dot,
  input logic [LW-1:0] line,
  input logic          a12
);

  logic [1:0] armed;
  always_ff @(posedge clk) begin
    if (rst) armed <= '0;
    else     armed <= {armed[0], 1'b1};
  end

  // R2
  dot_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (dot == DW'(DOTS_PER_LINE - 1)) |=> (dot == '0));

  // R2
  dot_step_chk: assert property (@(posedge clk) disable iff (rst)
    (dot != DW'(DOTS_PER_LINE - 1)) |=> (dot == $past(dot) + 1'b1));

  // R3
  line_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (dot != DW'(DOTS_PER_LINE - 1)) |=> $stable(line));

  // R3
  line_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (dot == DW'(DOTS_PER_LINE - 1) && line == LW'(LINES - 1)) |=> (line == '0));

  // R4
  idle_low_chk: assert property (@(posedge clk) disable iff (rst || !armed[0])
    ($past(render_en) && dot >= DW'(336)) |-> !a12);

  // R4
  rise_phase_chk: assert property (@(posedge clk) disable iff (rst || !armed[1])
    ($rose(a12) && $past(render_en) && $past(render_en, 2)) |-> (dot[2:0] == 3'd4));

  // R8
  cpu_follow_chk: assert property (@(posedge clk) disable iff (rst || !armed[0])
    !$past(render_en) |-> (a12 == $past(vram_a12)));

endmodule

bind pattern_a12_seq pattern_a12_seq_chk #(
  .DOTS_PER_LINE(DOTS_PER_LINE),
  .LINES        (LINES)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .render_en(render_en),
  .vram_a12 (vram_a12),
  .dot      (dot),
  .line     (line),
  .a12      (a12)
);

// File: tb/tb_pattern_a12_seq.sv
module tb_pattern_a12_seq;

  localparam int CLK_PERIOD = 10;
  localparam int NLINES     = 5;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       render_en = 1'b0;
  logic       bg_tbl = 1'b0;
  logic       spr_tbl = 1'b0;
  logic       spr_tall = 1'b0;
  logic [7:0] spr_slot_tbl = 8'h00;
  logic       vram_a12 = 1'b0;
  logic [8:0] dot;
  logic [2:0] line;
  logic       a12;

  pattern_a12_seq #(.LINES(NLINES)) dut (
    .clk(clk), .rst(rst), .render_en(render_en), .bg_tbl(bg_tbl),
    .spr_tbl(spr_tbl), .spr_tall(spr_tall), .spr_slot_tbl(spr_slot_tbl),
    .vram_a12(vram_a12), .dot(dot), .line(line), .a12(a12)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  // reference model state
  int mdot = 0, mline = 0;
  bit mexp = 0;
  bit exp_ren = 0;
  int exp_kind = 0;   // 0 bg, 1 sprite (8x8), 2 sprite (8x16), 3 idle

  // rise tracking
  int  line_mode = 0;  // 0 none, 1 bg0/sp1, 2 bg1/sp0
  int  rises = 0, first_late = -1;
  int  last_rise_cyc = -100, last_rise_dot = -1;
  bit  prev_a12 = 0, prev_ren = 0;
  logic [15:0] lfsr = 16'hACE1;

  function automatic bit model_a12(int d, bit ren, bit bg, bit sp, bit tall,
                                   logic [7:0] st, bit va, output int kd);
    int k, ph;
    bit t;
    kd = 3;
    if (!ren) return va;
    if (d >= 336) return 1'b0;
    k  = d / 8;
    ph = d % 8;
    if (k < 32 || k >= 40) begin kd = 0; t = bg; end
    else if (tall) begin kd = 2; t = st[k-32]; end
    else begin kd = 1; t = sp; end
    return (ph == 4 || ph == 5) ? t : 1'b0;
  endfunction

  task automatic check(bit ok, string req, int act, int expv, string what);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0d expected=%0d (dot %0d)", req, what, act, expv, mdot);
    end
  endtask

  function automatic string a12_req();
    if (!exp_ren) return "R8";
    case (exp_kind)
      0: return "R5";
      1: return "R6";
      2: return "R7";
      default: return "R4";
    endcase
  endfunction

  // One clock: model update at the edge, compare at the falling edge.
  task automatic step();
    int kd;
    @(posedge clk);
    cyc++;
    if (rst) begin
      mdot = 0; mline = 0; mexp = 0; exp_ren = 0; exp_kind = 3;
    end else begin
      if (mdot == 340) begin
        mdot = 0;
        mline = (mline == NLINES-1) ? 0 : mline + 1;
      end else mdot++;
      mexp = model_a12(mdot, render_en, bg_tbl, spr_tbl, spr_tall, spr_slot_tbl, vram_a12, kd);
      exp_ren = render_en; exp_kind = kd;
    end
    @(negedge clk);
    // R2, R3, R10: registered outputs match the model on every clock
    check(dot == 9'(mdot), "R2", int'(dot), mdot, "dot");
    check(line == 3'(mline), "R3", int'(line), mline, "line");
    check(a12 == mexp, a12_req(), int'(a12), int'(mexp), "a12");
    // R9 rise bookkeeping
    if (!rst && a12 && !prev_a12 && exp_ren && prev_ren) begin
      rises++;
      if (mdot >= 256 && first_late < 0) first_late = mdot;
      if (line_mode == 2 && mdot == 4 && last_rise_dot == 332)
        check((cyc - last_rise_cyc) == 13, "R9", cyc - last_rise_cyc, 13, "gap 332->4");
      last_rise_cyc = cyc; last_rise_dot = mdot;
    end
    prev_a12 = a12; prev_ren = exp_ren;
    if (!rst && mdot == 340) begin
      if (line_mode == 1) begin
        check(rises == 8, "R9", rises, 8, "rises bg0/sp1");
        check(first_late == 260, "R9", first_late, 260, "first rise bg0/sp1");
      end else if (line_mode == 2) begin
        check(rises == 34, "R9", rises, 34, "rises bg1/sp0");
        check(first_late == 324, "R9", first_late, 324, "late rise bg1/sp0");
      end
      rises = 0; first_late = -1;
    end
  endtask

  // Run until the model sits on dot 340, so the next edge starts a line.
  task automatic to_line_end();
    while (mdot != 340) step();
  endtask

  task automatic run_line(int mode);
    line_mode = mode;
    repeat (341) step();
  endtask

  initial begin
    int start;
    rst = 1'b1;
    repeat (3) step();
    // R1: reset state
    check(dot == 9'd0, "R1", int'(dot), 0, "reset dot");
    check(line == 3'd0, "R1", int'(line), 0, "reset line");
    check(a12 == 1'b0, "R1", int'(a12), 0, "reset a12");
    render_en = 1'b1; bg_tbl = 1'b0; spr_tbl = 1'b1;
    rst = 1'b0;
    to_line_end();
    // R9, R5, R6: standard arrangement for two lines
    run_line(1);
    run_line(1);
    // R9: reversed arrangement, three lines to cover the line wrap gap
    bg_tbl = 1'b1; spr_tbl = 1'b0;
    run_line(2);
    run_line(2);
    run_line(2);
    // R5, R6: both tables 1
    spr_tbl = 1'b1;
    run_line(0);
    // R7: 8x16 per-slot tables; spr_tbl toggled mid-line must not matter
    bg_tbl = 1'b0; spr_tall = 1'b1; spr_slot_tbl = 8'b1010_0110;
    repeat (280) step();
    spr_tbl = 1'b0;
    to_line_end();
    spr_slot_tbl = 8'b0101_1001;
    run_line(0);
    // R10: mid-line change of background table, seen after one edge
    spr_tall = 1'b0;
    repeat (100) step();
    bg_tbl = 1'b1;
    repeat (60) step();
    bg_tbl = 1'b0;
    to_line_end();
    // R8: rendering off, pseudo-random CPU address bit and moving selects
    render_en = 1'b0;
    for (int i = 0; i < 700; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      vram_a12 = lfsr[0];
      bg_tbl = lfsr[3]; spr_tbl = lfsr[5];
      step();
    end
    // R4, R8: back on with idle dots covered; then reset mid-frame (R1)
    vram_a12 = 1'b1; bg_tbl = 1'b1; spr_tbl = 1'b1;
    render_en = 1'b1;
    start = cyc;
    while (cyc - start < 900) step();
    rst = 1'b1;
    step();
    check(dot == 9'd0 && line == 3'd0 && a12 == 1'b0, "R1",
          int'(dot) + int'(line) + int'(a12), 0, "reset mid-frame");
    rst = 1'b0;
    // R3: run through a full frame wrap
    repeat (341 * NLINES + 20) step();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    fails++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule